// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one core's load/store port and a single-ported shared memory. A store is taken into a small local queue at once, so the core goes on to its next operation without waiting for the write to reach memory. Queued stores are written back one at a time, oldest first, and each one counts as visible to other agents only once memory has answered its write.

A load first searches the queue. If one or more queued stores match its address, the most recently issued one supplies the data, one cycle later. If none match, the load becomes a memory read, and its data is passed back in the cycle the memory answers. A fence is held at the request channel until the queue has fully drained, then acknowledged one cycle later. Together these rules give total-store-order behaviour for the core.

The memory port carries one transaction at a time, and every transaction, write or read, ends with exactly one response pulse. Write-back has priority on the port, so a missed load is issued only once the queue is empty.

Top module: `tso_store_buffer`

## Requirements
- R1: A store (req_op = 1) is accepted in any cycle in which no missed load is outstanding and the queue is not full. `empty` reads 0 from the cycle after the first store is accepted.
- R2: While the queue holds DEPTH entries, req_ready is 0 for a store. It returns to 1 in the cycle after a write response retires an entry.
- R3: A load (req_op = 0) whose address matches a queued store gets rsp_valid in the cycle after it is accepted. The data is that of the youngest matching store.
- R4: A load with no matching queued store issues one memory read (mem_req_we = 0) to its address. rsp_valid and rsp_data follow mem_rsp_valid and mem_rsp_data in the response cycle.
- R5: Queued stores go out as memory writes (mem_req_we = 1) in the order they were accepted, carrying their address and data. An entry leaves the queue only on its write response.
- R6: Only one memory transaction is outstanding at a time. A memory read is requested only while the queue is empty.
- R7: A fence (req_op = 2 or 3) is accepted only while the queue is empty. fence_ack pulses for one cycle, in the cycle after acceptance.
- R8: While a missed load awaits its response, req_ready is 0 for every operation.
- R9: In reset, empty is 1 and rsp_valid, fence_ack and mem_req_valid are 0.
- R10: A memory request that is not accepted stays asserted with the same address, write flag and data until mem_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted this cycle when valid |
| req_op | input | 2 | 0 load, 1 store, 2 or 3 fence |
| req_addr | input | AW | Load or store address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | DW | Load data |
| fence_ack | output | 1 | One-cycle fence completion pulse |
| empty | output | 1 | Queue holds no store |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | AW | Memory address |
| mem_req_wdata | output | DW | Memory write data |
| mem_rsp_valid | input | 1 | Memory response for the outstanding transaction |
| mem_rsp_data | input | DW | Read data |

## Verification
Each result has a fixed due cycle. req_ready and the memory request are combinational in the current cycle. A forwarded load answers exactly one cycle after acceptance, and a missed load answers in the same cycle as the memory response. fence_ack comes one cycle after the fence is accepted, and `empty` changes one cycle after an accepted store or a write response. The reference model advances once per clock from the handshakes it has just seen, so each expectation is compared in the cycle it is due, sampled between edges, with memory latency and back-pressure varied at random.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2
  } sb_op_e;
endpackage

// File: rtl/sb_entries.sv
module sb_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] srch_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   count;
  logic [PW-1:0] idx;

  // storage written without reset
  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full      = (count == (PW+1)'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    idx      = rd_ptr;
    for (int i = 0; i < DEPTH; i++) begin
      idx = rd_ptr + PW'(i);
      if (((PW+1)'(i) < count) && (addr_q[idx] == srch_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[idx];
      end
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sb_mem_ctl.sv
module sb_mem_ctl #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drain_req,
  input  logic [AW-1:0] drain_addr,
  input  logic [DW-1:0] drain_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  output logic          wr_done,
  output logic          rd_done
);
  logic busy_q, wr_q;

  // write-back wins over a read whenever both want the port
  assign mem_req_valid = !busy_q && (drain_req || rd_req);
  assign mem_req_we    = drain_req;
  assign mem_req_addr  = drain_req ? drain_addr : rd_addr;
  assign mem_req_wdata = drain_data;
  assign wr_done       = busy_q && wr_q && mem_rsp_valid;
  assign rd_done       = busy_q && !wr_q && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      busy_q <= 1'b1;
      wr_q   <= mem_req_we;
    end else if (mem_rsp_valid) begin
      busy_q <= 1'b0;
    end
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_we) && $stable(mem_req_addr)));
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          fence_ack,
  output logic          empty,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import sb_pkg::*;

  logic          full, sb_empty, hit, wr_done, rd_done;
  logic [DW-1:0] hit_data, head_data;
  logic [AW-1:0] head_addr;
  logic          accept, push, load_acc, fence_acc;
  logic          ld_miss_q, hit_rsp_q, fence_ack_q;
  logic [AW-1:0] ld_addr_q;
  logic [DW-1:0] hit_data_q;

  always_comb begin
    case (req_op)
      OP_LOAD:  req_ready = !ld_miss_q;
      OP_STORE: req_ready = !ld_miss_q && !full;
      default:  req_ready = !ld_miss_q && sb_empty;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign push      = accept && (req_op == OP_STORE);
  assign load_acc  = accept && (req_op == OP_LOAD);
  assign fence_acc = accept && (req_op[1] == 1'b1);

  sb_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_entries (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (wr_done),
    .srch_addr (req_addr),
    .hit       (hit),
    .hit_data  (hit_data),
    .head_addr (head_addr),
    .head_data (head_data),
    .full      (full),
    .empty     (sb_empty)
  );

  sb_mem_ctl #(.AW(AW), .DW(DW)) u_mem (
    .clk           (clk),
    .rst           (rst),
    .drain_req     (!sb_empty),
    .drain_addr    (head_addr),
    .drain_data    (head_data),
    .rd_req        (ld_miss_q && sb_empty),
    .rd_addr       (ld_addr_q),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .wr_done       (wr_done),
    .rd_done       (rd_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_miss_q   <= 1'b0;
      ld_addr_q   <= '0;
      hit_rsp_q   <= 1'b0;
      hit_data_q  <= '0;
      fence_ack_q <= 1'b0;
    end else begin
      hit_rsp_q   <= load_acc && hit;
      hit_data_q  <= hit_data;
      fence_ack_q <= fence_acc;
      if (load_acc && !hit) begin
        ld_miss_q <= 1'b1;
        ld_addr_q <= req_addr;
      end else if (rd_done) begin
        ld_miss_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = hit_rsp_q || rd_done;
  assign rsp_data  = hit_rsp_q ? hit_data_q : mem_rsp_data;
  assign fence_ack = fence_ack_q;
  assign empty     = sb_empty;

  p_hit_next_r3: assert property (@(posedge clk) disable iff (rst)
    (load_acc && hit) |=> rsp_valid);
  p_read_when_drained_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_we) |-> sb_empty);
  p_fence_drained_r7: assert property (@(posedge clk) disable iff (rst)
    fence_ack |-> empty);
  p_full_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (full && req_valid && req_op == OP_STORE) |-> !req_ready);
  p_miss_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (load_acc && !hit) |=> !req_ready);
endmodule

// File: tb/tb_tso_store_buffer.sv
module tb_tso_store_buffer;
  localparam int DEPTH = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_ready;
  logic [1:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic rsp_valid, fence_ack, empty;
  logic [DW-1:0] rsp_data;
  logic mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;

  always #10 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .fence_ack(fence_ack), .empty(empty),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int nchk = 0;
  int nerr = 0;

  logic [DW-1:0] mem_model [logic [AW-1:0]];
  logic [AW-1:0] sq_addr [$];
  logic [DW-1:0] sq_data [$];

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // model state
  bit mbusy, mwe, pend_miss, hit_due, fence_due, prev_wait;
  int mwait;
  logic [AW-1:0] maddr, miss_addr, prev_addr;
  logic [DW-1:0] mdata, miss_exp, hit_val;
  bit cur_valid;
  int k, idle;

  task automatic new_request();
    int r;
    cur_valid = 1'b1;
    req_wdata = 32'hA000 + k;
    if (k < 8) begin
      req_op = 2'd1;
      req_addr = (k % 3 == 0) ? 32'h14 : 32'h10;
    end else if (k == 8) begin
      req_op = 2'd0; req_addr = 32'h10;   // youngest 0x10 store: A007
    end else if (k == 9) begin
      req_op = 2'd0; req_addr = 32'h14;   // youngest 0x14 store: A006
    end else if (k == 10) begin
      req_op = 2'd1; req_addr = 32'h18;   // stalls while full
    end else if (k == 11) begin
      req_op = 2'd2; req_addr = 32'h0;
    end else if (k == 12) begin
      req_op = 2'd0; req_addr = 32'h30;   // miss
    end else begin
      if ($urandom_range(0, 4) == 0) cur_valid = 1'b0;
      r = $urandom_range(0, 19);
      req_op = (r < 9) ? 2'd1 : (r < 17) ? 2'd0 : ((r & 1) ? 2'd3 : 2'd2);
      req_addr = {28'd0, 2'($urandom_range(0, 3)), 2'b00};
    end
    if (cur_valid) k++;
  endtask

  initial begin
    bit exp_rdy, exp_rv, exp_mv, exp_we, acc, mh, found, wd;
    logic [AW-1:0] exp_ma;
    logic [DW-1:0] exp_rd, exp_wd, fv;
    string rtag;

    rst = 1'b1;
    req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    mbusy = 0; mwe = 0; pend_miss = 0; hit_due = 0; fence_due = 0;
    prev_wait = 0; mwait = 0; maddr = 0; mdata = 0; miss_addr = 0;
    miss_exp = 0; hit_val = 0; prev_addr = 0; cur_valid = 0; k = 0; idle = 0;
    wd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(empty == 1'b1, "R9 empty in reset", 32'(empty), 32'd1);
    chk(rsp_valid == 1'b0, "R9 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    chk(fence_ack == 1'b0, "R9 fence_ack in reset", 32'(fence_ack), 32'd0);
    chk(mem_req_valid == 1'b0, "R9 mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
    rst = 1'b0;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!cur_valid) new_request();
      req_valid = cur_valid;
      mem_req_ready = (cyc < 40) ? 1'b0 : ($urandom_range(0, 3) != 0);
      mem_rsp_valid = mbusy && (mwait == 0);
      mem_rsp_data = (mbusy && !mwe) ? mem_rd(maddr) : 32'hDEAD_BEEF;
      #1;

      // expectations for this cycle
      exp_rdy = pend_miss ? 1'b0 :
                (req_op == 2'd0) ? 1'b1 :
                (req_op == 2'd1) ? (sq_addr.size() < DEPTH) :
                (sq_addr.size() == 0);
      rtag = (req_op == 2'd0) ? "R8 ready for load" :
             (req_op == 2'd1) ? "R2 ready for store" : "R7 ready for fence";
      if (pend_miss) rtag = "R8 ready while miss outstanding";
      if (req_valid) chk(req_ready == exp_rdy, rtag, 32'(req_ready), 32'(exp_rdy));

      chk(empty == (sq_addr.size() == 0), "R1 empty flag", 32'(empty),
          32'(sq_addr.size() == 0));

      exp_rv = hit_due || (mem_rsp_valid && mbusy && !mwe);
      exp_rd = hit_due ? hit_val : miss_exp;
      chk(rsp_valid == exp_rv, hit_due ? "R3 hit rsp_valid" : "R4 rsp_valid",
          32'(rsp_valid), 32'(exp_rv));
      if (exp_rv && rsp_valid)
        chk(rsp_data == exp_rd, hit_due ? "R3 youngest forwarded data" : "R4 miss data",
            rsp_data, exp_rd);

      chk(fence_ack == fence_due, "R7 fence_ack", 32'(fence_ack), 32'(fence_due));

      exp_mv = !mbusy && (sq_addr.size() > 0 || pend_miss);
      exp_we = sq_addr.size() > 0;
      exp_ma = exp_we ? sq_addr[0] : miss_addr;
      exp_wd = exp_we ? sq_data[0] : 32'd0;
      chk(mem_req_valid == exp_mv, "R6 mem_req_valid", 32'(mem_req_valid), 32'(exp_mv));
      if (exp_mv && mem_req_valid) begin
        chk(mem_req_we == exp_we, "R6 read only when drained", 32'(mem_req_we), 32'(exp_we));
        chk(mem_req_addr == exp_ma, "R5 drain order address", mem_req_addr, exp_ma);
        if (exp_we) chk(mem_req_wdata == exp_wd, "R5 drain order data", mem_req_wdata, exp_wd);
        if (prev_wait) chk(mem_req_addr == prev_addr, "R10 held request", mem_req_addr, prev_addr);
      end

      // advance the model across the coming edge
      acc = req_valid && exp_rdy;
      mh  = exp_mv && mem_req_ready;
      prev_wait = exp_mv && !mem_req_ready;
      prev_addr = exp_ma;
      hit_due = 1'b0;
      if (acc && req_op == 2'd0) begin
        found = 1'b0; fv = '0;
        foreach (sq_addr[i]) if (sq_addr[i] == req_addr) begin found = 1'b1; fv = sq_data[i]; end
        if (found) begin hit_due = 1'b1; hit_val = fv; end
        else begin pend_miss = 1'b1; miss_addr = req_addr; miss_exp = mem_rd(req_addr); end
      end
      if (mem_rsp_valid) begin
        if (mwe) begin
          mem_model[maddr] = mdata;
          void'(sq_addr.pop_front());
          void'(sq_data.pop_front());
        end else begin
          pend_miss = 1'b0;
        end
        mbusy = 1'b0;
      end else if (mbusy) begin
        mwait--;
      end
      if (mh) begin
        mbusy = 1'b1; mwe = exp_we; maddr = exp_ma; mdata = exp_wd;
        mwait = $urandom_range(0, 2);
      end
      if (acc && req_op == 2'd1) begin
        sq_addr.push_back(req_addr);
        sq_data.push_back(req_wdata);
      end
      fence_due = acc && req_op[1];
      if (acc) begin cur_valid = 1'b0; idle = 0; end
      else idle++;
      if (idle > 400) begin
        wd = 1'b1;
        break;
      end
    end
    if (wd) begin
      nchk++; nerr++;
      $display("FAIL R8 watchdog: no request accepted for 400 cycles actual=0 expected=1");
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule